// File: doc/BRIEF.md
# Power-of-Two Twiddle Butterfly for a Fermat-Modulus Transform

This block performs one butterfly step of a number-theoretic transform whose arithmetic runs modulo m = 2^P + 1. Because the root of unity is a power of two, the twiddle product needs no multiplier. The second operand is shifted left, and any bits that pass position P-1 are folded back into the low bits with their sign inverted, since 2^P is congruent to -1 modulo m. The shifted value is then added to the first operand and subtracted from it, both modulo m.

One select input chooses the forward or the inverse direction. In the inverse direction the twiddle exponent is negated modulo 2P. Both results are also multiplied by 1/T, which is the negated power of two -2^(P-log2 T), and that product is again done as a shift. Residues are carried in P+1 bits so that 2^P (that is, -1) can be represented. The result is registered one cycle after a valid input.

A two-state controller tracks whether the output registers hold a fresh result. State S_IDLE means no result was captured on the last edge. State S_SHOW means a result was captured on the last edge. The transitions are: S_IDLE to S_SHOW on valid_in (capture), S_SHOW to S_SHOW on valid_in (capture again), S_SHOW to S_IDLE when valid_in is low (hold), and S_IDLE to S_IDLE when valid_in is low.

Top module: `nttb_butterfly`

## Requirements
- R1: Every sum_out and diff_out value lies in the range 0 to 2^P inclusive, where 2^P + 1 is the modulus m (65537 with P = 16).
- R2: In forward mode (inverse = 0), with t = b * 2^(W*idx) mod m and W = 2P/T (4 by default), sum_out = (a + t) mod m and diff_out = (a - t) mod m.
- R3: Twiddle shifts that move bits past position P-1 wrap those bits back negated. For example, forward with idx = 4, a = 0 and b = 1 gives t = 2^16 ≡ -1, so sum_out = 65536 and diff_out = 1.
- R4: In inverse mode (inverse = 1), with t = b * 2^(-W*idx) mod m, sum_out = (a + t) * T^-1 mod m and diff_out = (a - t) * T^-1 mod m, where T^-1 = -2^(P - log2 T) mod m.
- R5: The residue 2^P (the value -1) is accepted on a and b and gives correct results in both modes.
- R6: valid_out is high in the cycle after an edge that sampled valid_in high, and low in the cycle after an edge that sampled valid_in low.
- R7: While valid_in is low, sum_out and diff_out keep their last values whatever a, b, idx and inverse do.
- R8: After reset, valid_out, sum_out and diff_out are all 0.
- R9: In forward mode with idx = 0, the twiddle is 1, so the outputs are plain (a + b) mod m and (a - b) mod m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Operands are presented this cycle |
| inverse | input | 1 | 1 selects the inverse direction with 1/T scaling |
| idx | input | log2(T) | Twiddle exponent index, 0 to T-1 |
| a | input | P+1 | First residue, 0 to 2^P |
| b | input | P+1 | Second residue, which receives the twiddle, 0 to 2^P |
| valid_out | output | 1 | Registered results are fresh |
| sum_out | output | P+1 | Registered (a + twiddled b), scaled in inverse mode |
| diff_out | output | P+1 | Registered (a - twiddled b), scaled in inverse mode |

## Verification
A controller stuck in the wrong state shows up within one cycle as a mismatch on valid_out, because that output is derived directly from the state. A wrong fold of the high bits, a wrong exponent negation or a wrong scaling shift reaches sum_out and diff_out on the edge right after the stimulus. The bench therefore compares every output on every clock against a behavioural model that uses modular exponentiation and Fermat inverses rather than shifts. Loading the output registers wrongly during idle cycles shows up on the first hold cycle as changed outputs.

// File: rtl/nttb_pkg.sv
package nttb_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_SHOW = 1'b1
    } bfly_state_e;
endpackage

// File: rtl/nttb_shift_mod.sv
// Multiplies a residue by 2^sh modulo 2^P+1 using a shift and an alternating fold.
module nttb_shift_mod #(
    parameter int P  = 16,
    parameter int EW = $clog2(2 * P)
) (
    input  logic [P:0]    x,
    input  logic [EW-1:0] sh,
    output logic [P:0]    y
);
    localparam int PW = 3 * P;
    localparam logic signed [P+2:0] MODS = (P + 3)'((64'd1 << P) + 64'd1);

    logic [PW-1:0]       prod;
    logic [P-1:0]        c_lo, c_mid, c_hi;
    logic signed [P+2:0] raw, fixd;

    always_comb begin
        prod  = PW'(x) << sh;
        c_lo  = prod[P-1:0];
        c_mid = prod[2*P-1:P];
        c_hi  = prod[3*P-1:2*P];
        // 2^P == -1 and 2^(2P) == +1 modulo m
        raw = $signed({3'b000, c_lo}) + $signed({3'b000, c_hi})
            - $signed({3'b000, c_mid});
        if (raw < 0)
            fixd = raw + MODS;
        else if (raw >= MODS)
            fixd = raw - MODS;
        else
            fixd = raw;
        y = (P + 1)'(fixd);
    end
endmodule

// File: rtl/nttb_addsub.sv
// Modular add and subtract of two reduced residues.
module nttb_addsub #(
    parameter int P = 16
) (
    input  logic [P:0] a,
    input  logic [P:0] t,
    output logic [P:0] sum,
    output logic [P:0] diff
);
    localparam logic [P+1:0]        MODU = (P + 2)'((64'd1 << P) + 64'd1);
    localparam logic signed [P+2:0] MODS = (P + 3)'((64'd1 << P) + 64'd1);

    logic [P+1:0]        s_raw;
    logic signed [P+2:0] d_raw, d_fix;

    always_comb begin
        s_raw = {1'b0, a} + {1'b0, t};
        sum   = (s_raw >= MODU) ? (P + 1)'(s_raw - MODU) : (P + 1)'(s_raw);
        d_raw = $signed({2'b00, a}) - $signed({2'b00, t});
        d_fix = (d_raw < 0) ? (d_raw + MODS) : d_raw;
        diff  = (P + 1)'(d_fix);
    end
endmodule

// File: rtl/nttb_butterfly.sv
module nttb_butterfly
    import nttb_pkg::*;
#(
    parameter int P = 16,
    parameter int T = 8,
    localparam int IW = $clog2(T),
    localparam int RW = P + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_in,
    input  logic          inverse,
    input  logic [IW-1:0] idx,
    input  logic [RW-1:0] a,
    input  logic [RW-1:0] b,
    output logic          valid_out,
    output logic [RW-1:0] sum_out,
    output logic [RW-1:0] diff_out
);
    localparam int EW    = $clog2(2 * P);
    localparam int W     = (2 * P) / T;
    localparam int LT    = $clog2(T);
    localparam int SC_SH = 2 * P - LT;
    localparam longint MODV = (64'd1 << P) + 64'd1;

    bfly_state_e   state_q, state_d;
    logic [EW-1:0] fw_sh, inv_sh, tw_sh;
    logic [RW-1:0] tw_b;
    logic [RW-1:0] lane_pre [2];
    logic [RW-1:0] lane_scl [2];
    logic [RW-1:0] nxt_sum, nxt_diff;

    // Twiddle exponent: W*idx forward, negated modulo 2P inverse
    always_comb begin
        fw_sh  = EW'(W * int'(idx));
        inv_sh = (fw_sh == '0) ? '0 : EW'(2 * P - W * int'(idx));
        tw_sh  = inverse ? inv_sh : fw_sh;
    end

    nttb_shift_mod #(.P(P), .EW(EW)) u_twiddle (
        .x  (b),
        .sh (tw_sh),
        .y  (tw_b)
    );

    nttb_addsub #(.P(P)) u_core (
        .a    (a),
        .t    (tw_b),
        .sum  (lane_pre[0]),
        .diff (lane_pre[1])
    );

    // 1/T scaling lanes, one per result
    for (genvar g = 0; g < 2; g++) begin : g_scale
        nttb_shift_mod #(.P(P), .EW(EW)) u_scale (
            .x  (lane_pre[g]),
            .sh (EW'(SC_SH)),
            .y  (lane_scl[g])
        );
    end

    always_comb begin
        nxt_sum  = inverse ? lane_scl[0] : lane_pre[0];
        nxt_diff = inverse ? lane_scl[1] : lane_pre[1];
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: state_d = valid_in ? S_SHOW : S_IDLE;
            S_SHOW: state_d = valid_in ? S_SHOW : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_out  <= '0;
            diff_out <= '0;
        end else if (valid_in) begin
            sum_out  <= nxt_sum;
            diff_out <= nxt_diff;
        end
    end

    // Output decode
    always_comb begin
        valid_out = (state_q == S_SHOW);
    end

    // Assertions
    a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (longint'(sum_out) < MODV && longint'(diff_out) < MODV));

    a_r6_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);

    a_r6_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(sum_out) && $stable(diff_out)));

    a_r9_unit_twiddle: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !inverse && idx == '0 &&
         longint'(a) < MODV && longint'(b) < MODV)
        |=> longint'(sum_out) == (longint'($past(a)) + longint'($past(b))) % MODV);
endmodule

// File: tb/test_nttb_butterfly.sv
module test_nttb_butterfly;
    localparam int P = 16;
    localparam int T = 8;
    localparam int W = 2 * P / T;
    localparam longint M = (64'd1 << P) + 64'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic        inverse = 1'b0;
    logic [2:0]  idx = '0;
    logic [P:0]  a = '0;
    logic [P:0]  b = '0;
    logic        valid_out;
    logic [P:0]  sum_out, diff_out;

    int     checks = 0;
    int     errors = 0;
    bit     done = 1'b0;
    bit     exp_v = 1'b0;
    longint exp_s = 0;
    longint exp_d = 0;

    always #5 clk = ~clk;

    nttb_butterfly #(.P(P), .T(T)) i_nttb_butterfly (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .inverse(inverse),
        .idx(idx), .a(a), .b(b), .valid_out(valid_out),
        .sum_out(sum_out), .diff_out(diff_out)
    );

    function automatic longint powmod(input longint base, input longint e);
        longint r = 1;
        longint bb = base % M;
        longint ee = e;
        while (ee > 0) begin
            if (ee[0]) r = (r * bb) % M;
            bb = (bb * bb) % M;
            ee = ee >> 1;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic step(input bit v, input bit inv, input int ix,
                        input longint av, input longint bv, input string tag);
        longint tw, t, s, d, tinv;
        @(negedge clk);
        valid_in = v; inverse = inv; idx = 3'(ix);
        a = (P + 1)'(av); b = (P + 1)'(bv);
        @(posedge clk);
        if (v) begin
            tw = powmod(2, W * ix);
            if (inv) tw = powmod(tw, M - 2);
            t = (bv * tw) % M;
            s = (av + t) % M;
            d = (av - t + M) % M;
            if (inv) begin
                tinv = powmod(T, M - 2);
                s = (s * tinv) % M;
                d = (d * tinv) % M;
            end
            exp_s = s;
            exp_d = d;
        end
        exp_v = v;
        #2;
        chk({tag, " R6 valid"}, longint'(valid_out), longint'(exp_v));
        chk({tag, " sum"}, longint'(sum_out), exp_s);
        chk({tag, " diff"}, longint'(diff_out), exp_d);
        if (v) begin
            chk("R1 sum range", longint'(sum_out < M), 1);
            chk("R1 diff range", longint'(diff_out < M), 1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R8 reset valid", longint'(valid_out), 0);
        chk("R8 reset sum", longint'(sum_out), 0);
        chk("R8 reset diff", longint'(diff_out), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: unit twiddle
        step(1, 0, 0, 100, 30, "R9 a+b");
        step(1, 0, 0, 30, 100, "R9 wrap diff");
        step(1, 0, 0, 65535, 10, "R9 wrap sum");
        // R3: negating wrap
        step(1, 0, 4, 0, 1, "R3 idx4");
        step(1, 0, 7, 3, 5, "R3 idx7");
        step(1, 0, 5, 65536, 65536, "R3 R5 minus-one");
        // R6: valid drops, R7: hold with changing inputs
        step(0, 1, 3, 12345, 999, "R7 hold");
        step(0, 0, 6, 1, 2, "R7 hold again");
        step(1, 1, 0, 65536, 0, "R4 R5 inverse minus-one");
        step(1, 1, 2, 7, 9, "R4 inverse idx2");
        // R2 and R4 over all indices
        for (int i = 0; i < T; i++) begin
            step(1, 0, i, longint'($urandom % 32'(M)), longint'($urandom % 32'(M)), "R2 forward");
            step(1, 1, i, longint'($urandom % 32'(M)), longint'($urandom % 32'(M)), "R4 inverse");
        end
        for (int k = 0; k < 300; k++) begin
            step(($urandom % 4) != 0, $urandom % 2, $urandom % T,
                 longint'($urandom % 32'(M)), longint'($urandom % 32'(M)), "R2 R4 R7 random");
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule